// File: doc/BRIEF.md
# Masked Reset-Cycle Sequencer

This block runs the reset and initialization phase for three peripheral sub-controllers: a DAC, an ADC and an Ethernet controller. It watches the system state value. When that value enters the reset code (all zeros), the block sends a one-cycle start pulse to every peripheral whose enable is set. It then waits for the done lines of those peripherals. A disabled peripheral counts as already finished. When the barrier is met, the block issues a one-cycle state-write pulse that carries the next state code (001) into the external state register.

The per-peripheral initialization engines sit outside this block. Each one is seen only as a start/done handshake. A peripheral's done line drops when it accepts a start pulse and rises when its initialization ends. The enables arrive from an upstream command decoder and stay stable during a reset cycle. The first reset cycle after a power-on reset ignores the enables and starts every peripheral.

Top module: `init_barrier_seq`

## Requirements
- R1: During reset (`rst_n` low), `dev_start` is 000, `st_we` is 0 and `st_next` is 000.
- R2: In the cycle after `state_q` changes from a non-zero code to 000, `dev_start` equals the enable vector (bit 0 DAC, bit 1 ADC, bit 2 Ethernet) for exactly one cycle.
- R3: While `state_q` stays 000, no further start pulse and no further `st_we` pulse are issued.
- R4: The first reset cycle after `rst_n` is released treats all three enables as set, whatever `dev_en` holds.
- R5: `st_we` rises in the cycle after the last enabled peripheral's done line is first sampled high following its start. With no peripheral enabled, `st_we` rises three cycles after the cycle in which `state_q` became 000.
- R6: A done line that is still high from an earlier cycle, in the cycle its start pulse is out, does not complete the barrier.
- R7: `st_we` is high for exactly one cycle per reset cycle.
- R8: `st_next` is 001 while `st_we` is high and 000 at all other times.
- R9: The done line of a disabled peripheral is ignored. It may stay low without holding back `st_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_q | input | 3 | Current value of the system state register |
| dev_en | input | 3 | Per-peripheral enables: bit 0 DAC, bit 1 ADC, bit 2 Ethernet |
| dev_done | input | 3 | Per-peripheral initialization-complete lines |
| dev_start | output | 3 | One-cycle start pulses to the peripherals |
| st_we | output | 1 | One-cycle write enable to the state register |
| st_next | output | 3 | Value to write into the state register |

## Verification
The bench builds the block with its default parameters: three peripherals, a 3-bit state, reset code 000 and next code 001. At this size, every enable pattern and every ordering of peripheral latencies can be reached within a few hundred cycles. The bench models each peripheral with its own programmable latency, so it can predict the exact cycle of `st_we` as three plus the longest enabled latency. Directed runs cover the power-on override, a disabled peripheral holding its done line low, and the state held at 000 after completion.

// File: rtl/init_barrier_seq_pkg.sv
package init_barrier_seq_pkg;

  // True when the state value equals the reset code.
  function automatic logic code_match(input logic [7:0] st, input logic [7:0] code);
    return st == code;
  endfunction

  // Barrier: every peripheral is either finished or masked out.
  function automatic logic barrier_met(input logic [7:0] done, input logic [7:0] en,
                                       input int unsigned n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) ok = ok & (done[i] | ~en[i]);
    return ok;
  endfunction

endpackage

// File: rtl/init_barrier_seq_trigger.sv
module init_barrier_seq_trigger #(
  parameter int unsigned N_DEV = 3,
  parameter int unsigned ST_W  = 3,
  parameter logic [ST_W-1:0] IDLE_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  state_q,
  input  logic [N_DEV-1:0] dev_en,
  output logic             go,
  output logic [N_DEV-1:0] en_eff
);
  import init_barrier_seq_pkg::*;

  logic act, act_q, por_pend;

  assign act    = code_match(8'(state_q), 8'(IDLE_CODE));
  assign go     = act & ~act_q;
  assign en_eff = por_pend ? {N_DEV{1'b1}} : dev_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      por_pend <= 1'b1;
    end else begin
      act_q <= act;
      if (go) por_pend <= 1'b0;
    end
  end

  AST_GO_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> state_q == IDLE_CODE); // R2
  AST_NO_REGO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go); // R3
endmodule

// File: rtl/init_barrier_seq_launch.sv
module init_barrier_seq_launch #(
  parameter int unsigned N_DEV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [N_DEV-1:0] en_eff,
  output logic [N_DEV-1:0] dev_start,
  output logic [N_DEV-1:0] en_lat,
  output logic             launched
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dev_start[i] <= 1'b0;
        en_lat[i]    <= 1'b1;
      end else begin
        dev_start[i] <= go & en_eff[i];
        if (go) en_lat[i] <= en_eff[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) launched <= 1'b0;
    else        launched <= go;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_start) |=> !(|dev_start)); // R2
endmodule

// File: rtl/init_barrier_seq_barrier.sv
module init_barrier_seq_barrier #(
  parameter int unsigned N_DEV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launched,
  input  logic [N_DEV-1:0] en_lat,
  input  logic [N_DEV-1:0] dev_done,
  input  logic [N_DEV-1:0] dev_start,
  output logic             st_we
);
  import init_barrier_seq_pkg::*;

  logic armed, met, cmp, cmp_q;

  assign met = barrier_met(8'(dev_done), 8'(en_lat), N_DEV);
  assign cmp = armed & met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cmp_q <= 1'b0;
      st_we <= 1'b0;
    end else begin
      if (launched)  armed <= 1'b1;
      else if (cmp)  armed <= 1'b0;
      cmp_q <= cmp;
      st_we <= cmp & ~cmp_q;
    end
  end

  AST_WE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> $past(&(dev_done | ~en_lat))); // R5
  AST_NO_WE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_start) |-> !st_we); // R6
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !st_we); // R7
endmodule

// File: rtl/init_barrier_seq.sv
module init_barrier_seq #(
  parameter int unsigned N_DEV = 3,
  parameter int unsigned ST_W  = 3,
  parameter logic [ST_W-1:0] IDLE_CODE = '0,
  parameter logic [ST_W-1:0] NEXT_CODE = ST_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  state_q,
  input  logic [N_DEV-1:0] dev_en,
  input  logic [N_DEV-1:0] dev_done,
  output logic [N_DEV-1:0] dev_start,
  output logic             st_we,
  output logic [ST_W-1:0]  st_next
);
  logic             go, launched;
  logic [N_DEV-1:0] en_eff, en_lat;

  init_barrier_seq_trigger #(.N_DEV(N_DEV), .ST_W(ST_W), .IDLE_CODE(IDLE_CODE)) u_trig (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .dev_en(dev_en),
    .go(go), .en_eff(en_eff));

  init_barrier_seq_launch #(.N_DEV(N_DEV)) u_launch (
    .clk(clk), .rst_n(rst_n), .go(go), .en_eff(en_eff),
    .dev_start(dev_start), .en_lat(en_lat), .launched(launched));

  init_barrier_seq_barrier #(.N_DEV(N_DEV)) u_bar (
    .clk(clk), .rst_n(rst_n), .launched(launched), .en_lat(en_lat),
    .dev_done(dev_done), .dev_start(dev_start), .st_we(st_we));

  assign st_next = st_we ? NEXT_CODE : IDLE_CODE;

  AST_START_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_start) |-> $past(state_q) == IDLE_CODE); // R2
endmodule

// File: tb/init_barrier_seq_test.sv
`timescale 1ns/1ps
module init_barrier_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] state_r = 3'b000;
  logic [2:0] dev_en = 3'b000;
  logic [2:0] dev_done = 3'b111;
  logic [2:0] dev_start;
  logic       st_we;
  logic [2:0] st_next;
  logic       hold = 1'b0;
  int         lat [3];
  int         cnt [3];
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  init_barrier_seq uut (
    .clk(clk), .rst_n(rst_n), .state_q(state_r), .dev_en(dev_en),
    .dev_done(dev_done), .dev_start(dev_start), .st_we(st_we), .st_next(st_next));

  // state register and peripheral models
  always @(posedge clk) if (rst_n && st_we && !hold) state_r <= st_next;
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (dev_start[i]) begin
        dev_done[i] <= 1'b0;
        cnt[i] <= lat[i];
      end else if (cnt[i] != 0) begin
        cnt[i] <= cnt[i] - 1;
        if (cnt[i] == 1) dev_done[i] <= 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector: {en[2:0], k0[3:0], k1[3:0], k2[3:0]}
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {3'b111, 4'd1, 4'd1, 4'd1},
    {3'b111, 4'd2, 4'd5, 4'd3},
    {3'b001, 4'd4, 4'd9, 4'd9},
    {3'b110, 4'd9, 4'd2, 4'd6},
    {3'b000, 4'd3, 4'd3, 4'd3},
    {3'b100, 4'd1, 4'd1, 4'd7},
    {3'b010, 4'd5, 4'd12, 4'd3}
  };

  // Called in the cycle state becomes 000 (n = 0); follows the run to st_we.
  task automatic follow(input logic [2:0] exp_start);
    int mx, seen;
    mx = 0;
    for (int i = 0; i < 3; i++) if (exp_start[i] && lat[i] > mx) mx = lat[i];
    seen = -1;
    for (int n = 1; n <= mx + 5; n++) begin
      @(negedge clk);
      if (n == 1) check(dev_start == exp_start, "R2 start", dev_start, exp_start);
      if (n == 2) check(dev_start == 3'b000, "R2 single", dev_start, 0);
      if (st_we && seen < 0) begin
        seen = n;
        check(n == mx + 3, "R5 latency", n, mx + 3);
        check(st_next == 3'b001, "R8 next", st_next, 1);
      end else if (seen > 0 && n == seen + 1) begin
        check(!st_we, "R7 one cycle", st_we, 0);
        check(st_next == 3'b000, "R8 idle", st_next, 0);
      end
      if (n == 2 && mx > 0) check(!st_we, "R6 stale done", st_we, 0);
    end
    check(seen > 0, "R5 reached", seen, mx + 3);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin lat[i] = 2 + i; cnt[i] = 0; end
    // R1: reset values
    #12;
    check(dev_start == 3'b000 && !st_we && st_next == 3'b000, "R1 reset",
          {st_we, st_next, dev_start}, 0);
    // R4: power-on run starts all devices though dev_en = 000
    @(negedge clk);
    rst_n = 1'b1;
    follow(3'b111);
    @(negedge clk);
    check(state_r == 3'b001, "R8 written", state_r, 1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      dev_en = VEC[v][14:12];
      lat[0] = VEC[v][11:8];
      lat[1] = VEC[v][7:4];
      lat[2] = VEC[v][3:0];
      // R9: disabled peripherals hold done low
      for (int i = 0; i < 3; i++) if (!dev_en[i]) dev_done[i] = 1'b0;
      state_r = 3'b010;
      @(negedge clk);
      @(negedge clk);
      state_r = 3'b000;
      follow(VEC[v][14:12]);
      @(negedge clk);
      check(state_r == 3'b001, "R9 barrier", state_r, 1);
    end

    // R3: state held at 000 after completion, no repeats
    hold = 1'b1;
    dev_en = 3'b111;
    lat[0] = 1; lat[1] = 2; lat[2] = 1;
    state_r = 3'b011;
    @(negedge clk);
    state_r = 3'b000;
    follow(3'b111);
    begin
      int extra;
      extra = 0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (dev_start != 0 || st_we) extra++;
      end
      check(extra == 0, "R3 no repeat", extra, 0);
    end
    hold = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule